// File: doc/BRIEF.md
# T1 Frame-Slip Elastic Store

This block sits between a recovered T1 line bit stream and a backplane that reads at its own rate. A single fast system clock runs the whole block. Each side has its own one-cycle bit strobe. The write side fills a store that holds two 193-bit frames, and the frame-start marker keeps it aligned. The read side empties the store either as the same 193-bit frames, or padded into a 32-timeslot, 256-bit frame for a 2.048 Mbps backplane.

The two sides are not locked to each other, so their frame distance drifts. At every read-side frame boundary the block checks how far the writer is ahead. If the reader is about to catch up with the writer, it repeats the frame it just read. If the writer is about to lap the reader, the reader skips one whole frame. Either event sets sticky flags. A recentre pulse puts the two pointers one frame apart. With the enable low, the store is bypassed and line bits pass straight to the output.

Top module: `t1_slip_buffer`

## Requirements
- R1: While reset is asserted, `rd_bit`, `rd_fs`, `slip_flag`, `empty_slip` and `full_slip` are all 0.
- R2: With `es_en`=1 and `e1_mode`=0, each read strobe outputs the next bit of a 193-bit frame, bit 0 (the F-bit) first. `rd_fs` is 1 exactly on bit 0. Frames come out in write order, unless a slip occurs.
- R3: With `es_en`=1 and `e1_mode`=1, each read frame is 256 bits: 32 timeslots of 8 bits. Every bit of timeslots 0, 4, 8, …, 28 is 1, except bit 0 of timeslot 0, which carries the F-bit. T1 channel k (k=0..23, 8 bits each, taken in T1 order) fills timeslot k + k/3 + 1. `rd_fs` is 1 on the first bit.
- R4: The slip test is made only on the read strobe of a frame's last bit. The writer's frame count includes a writer that is within `SLIP_GUARD` bits of finishing its frame. If the writer is then less than two frames ahead of the frame being left, the same frame is read again, and `slip_flag` and `empty_slip` are set.
- R5: If at that same test the writer is three frames ahead, the next frame is skipped and the reader moves two frames on. `slip_flag` and `full_slip` are set.
- R6: The flags stay set until a one-cycle `flag_clr`. A slip in the same cycle as `flag_clr` leaves its flags set.
- R7: `recenter` puts the reader at the start of frame half 0 and the writer at the start of half 1. With equal rates and the writer a strobe ahead, no slip then occurs.
- R8: With `es_en`=0, each write strobe copies `wr_bit` and `wr_fs` to `rd_bit` and `rd_fs`, and read strobes have no effect.
- R9: Outputs change only on the clock after a strobe and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| es_en | input | 1 | 1 = use the store, 0 = bypass |
| e1_mode | input | 1 | 0 = 193-bit read frames, 1 = 256-bit timeslot frames |
| recenter | input | 1 | Pulse: put the pointers one frame apart |
| flag_clr | input | 1 | Pulse: clear the slip flags |
| wr_stb | input | 1 | Line bit strobe |
| wr_bit | input | 1 | Line data bit |
| wr_fs | input | 1 | Marks the F-bit of a line frame |
| rd_stb | input | 1 | Backplane bit strobe |
| rd_bit | output | 1 | Backplane data bit |
| rd_fs | output | 1 | High for the first bit of each output frame |
| slip_flag | output | 1 | Sticky: some slip occurred |
| empty_slip | output | 1 | Sticky: a frame was repeated |
| full_slip | output | 1 | Sticky: a frame was dropped |

## Verification
A slip and a flag clear can land in the same cycle. When that happens, the set must win. The bench provokes this during the slow-writer run: it raises `flag_clr` on exactly the read strobe where its own model predicts a repeat. It then expects `slip_flag` and `empty_slip` to be high once the run ends. A separate idle `flag_clr` afterwards must clear them. The scoreboard's frame numbers, and so every compared bit, also depend on the reader's skip or repeat landing on the right frame.

// File: rtl/t1_slip_buffer.sv
module t1_slip_buffer #(
  parameter int FRAME_BITS = 193,
  parameter int SLOT_BITS  = 8,
  parameter int E1_SLOTS   = 32,
  parameter int SLIP_GUARD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic es_en,
  input  logic e1_mode,
  input  logic recenter,
  input  logic flag_clr,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic wr_fs,
  input  logic rd_stb,
  output logic rd_bit,
  output logic rd_fs,
  output logic slip_flag,
  output logic empty_slip,
  output logic full_slip
);

  localparam int BUF_BITS = 2 * FRAME_BITS;
  localparam int BUF_W    = $clog2(BUF_BITS);
  localparam int IDX_W    = $clog2(FRAME_BITS);
  localparam int E1_BITS  = E1_SLOTS * SLOT_BITS;
  localparam int BIT_W    = $clog2(SLOT_BITS);
  localparam int SLOT_W   = $clog2(E1_SLOTS);
  localparam int POS_W    = BIT_W + SLOT_W;

  logic [BUF_BITS-1:0] store;
  logic [1:0]          wr_frm, rd_frm;
  logic [IDX_W-1:0]    wr_idx;
  logic [POS_W-1:0]    rd_pos;

  // write side
  wire             wr_jump = wr_fs && (wr_idx != '0);
  wire [1:0]       wr_cur  = wr_frm + {1'b0, wr_jump};
  wire [IDX_W-1:0] wr_at   = wr_jump ? '0 : wr_idx;
  wire             wr_last = wr_at == IDX_W'(FRAME_BITS - 1);
  wire [BUF_W-1:0] wr_addr = BUF_W'(wr_at) + (wr_cur[0] ? BUF_W'(FRAME_BITS) : '0);

  always_ff @(posedge clk)
    if (wr_stb) store[wr_addr] <= wr_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_frm <= 2'd1;
      wr_idx <= '0;
    end else if (recenter) begin
      wr_frm <= 2'd1;
      wr_idx <= '0;
    end else if (wr_stb) begin
      wr_frm <= wr_cur + {1'b0, wr_last};
      wr_idx <= wr_last ? '0 : wr_at + 1'b1;
    end

  // read side mapping
  wire [SLOT_W-1:0] ts     = rd_pos[BIT_W +: SLOT_W];
  wire [BIT_W-1:0]  tb     = rd_pos[BIT_W-1:0];
  wire              pad_ts = ts[1:0] == 2'b00;
  wire              f_pos  = rd_pos == '0;
  wire [SLOT_W-1:0] chan   = ts - (ts >> 2) - 1'b1;
  wire [POS_W-1:0]  e1_idx = f_pos ? '0 : {chan, tb} + 1'b1;
  wire [POS_W-1:0]  rd_at  = e1_mode ? e1_idx : rd_pos;
  wire [BUF_W-1:0]  rd_addr = BUF_W'(rd_at) + (rd_frm[0] ? BUF_W'(FRAME_BITS) : '0);
  wire              rd_val = (e1_mode && pad_ts && !f_pos) ? 1'b1 : store[rd_addr];
  wire [POS_W-1:0]  rd_max = e1_mode ? POS_W'(E1_BITS - 1) : POS_W'(FRAME_BITS - 1);
  wire              rd_end = rd_pos >= rd_max;

  // slip decision at the read frame boundary
  wire       near_end = wr_idx >= IDX_W'(FRAME_BITS - SLIP_GUARD);
  wire [1:0] depth    = wr_frm + {1'b0, near_end} - rd_frm;
  wire       rd_go    = es_en && rd_stb && !recenter;
  wire       slip_dn  = rd_go && rd_end && !depth[1];
  wire       slip_up  = rd_go && rd_end && (depth == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_frm <= '0;
      rd_pos <= '0;
    end else if (recenter) begin
      rd_frm <= '0;
      rd_pos <= '0;
    end else if (rd_go) begin
      if (rd_end) begin
        rd_pos <= '0;
        rd_frm <= rd_frm + (slip_dn ? 2'd0 : slip_up ? 2'd2 : 2'd1);
      end else begin
        rd_pos <= rd_pos + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_bit <= 1'b0;
      rd_fs  <= 1'b0;
    end else if (!es_en) begin
      if (wr_stb) begin
        rd_bit <= wr_bit;
        rd_fs  <= wr_fs;
      end
    end else if (rd_stb) begin
      rd_bit <= rd_val;
      rd_fs  <= f_pos;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slip_flag  <= 1'b0;
      empty_slip <= 1'b0;
      full_slip  <= 1'b0;
    end else begin
      slip_flag  <= slip_dn | slip_up | (slip_flag & ~flag_clr);
      empty_slip <= slip_dn | (empty_slip & ~flag_clr);
      full_slip  <= slip_up | (full_slip & ~flag_clr);
    end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    slip_flag && !flag_clr |=> slip_flag); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !rd_stb |=> !slip_flag && !empty_slip && !full_slip); // R6
  AST_KIND_NEEDS_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_slip || full_slip) |-> slip_flag); // R4
  AST_ONE_KIND_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_slip) |-> !$rose(empty_slip)); // R5
  AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    es_en && e1_mode && rd_stb && pad_ts && !f_pos |=> rd_bit); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb && !wr_stb |=> $stable(rd_bit) && $stable(rd_fs)); // R9

endmodule

// File: tb/t1_slip_buffer_tb.sv
module t1_slip_buffer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic es_en = 1'b1, e1_mode = 1'b0, recenter = 1'b0, flag_clr = 1'b0;
  logic wr_stb = 1'b0, wr_bit = 1'b0, wr_fs = 1'b0, rd_stb = 1'b0;
  logic rd_bit, rd_fs, slip_flag, empty_slip, full_slip;

  always #2 clk = ~clk;

  t1_slip_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .es_en(es_en), .e1_mode(e1_mode),
    .recenter(recenter), .flag_clr(flag_clr),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .wr_fs(wr_fs), .rd_stb(rd_stb),
    .rd_bit(rd_bit), .rd_fs(rd_fs), .slip_flag(slip_flag),
    .empty_slip(empty_slip), .full_slip(full_slip));

  localparam int FB = 193;
  localparam int GUARD = 32;

  int nchk = 0, nbad = 0;
  bit done = 0;
  int rfn, rpos, wfn, widx;
  bit exp_empty, exp_full;
  bit q_bit[$], q_fs[$], q_care[$];

  function automatic bit gen(int f, int i);
    if (i == 0) return bit'(f & 1);
    return bit'(((f * 5 + i * 3 + (i >> 3)) % 7) < 3);
  endfunction

  function automatic bit map_e1(int f, int pos);
    int ts, ch;
    if (pos == 0) return gen(f, 0);
    ts = pos / 8;
    if (ts % 4 == 0) return 1'b1;
    ch = ts - ts / 4 - 1;
    return gen(f, 1 + ch * 8 + pos % 8);
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && es_en && rd_stb) begin
      #1;
      if (q_bit.size() == 0) check("R2 queue", 1, 0);
      else begin
        bit b, f, c;
        b = q_bit.pop_front(); f = q_fs.pop_front(); c = q_care.pop_front();
        check(e1_mode ? "R3 frame start" : "R2 frame start", rd_fs, f);
        if (c) check(e1_mode ? "R3 data" : "R2 data", rd_bit, b);
      end
    end
  end

  task automatic do_recenter();
    @(negedge clk);
    recenter = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    recenter = 1'b0; flag_clr = 1'b0;
    rfn = 0; rpos = 0; wfn = 1; widx = 0;
    exp_empty = 0; exp_full = 0;
  endtask

  task automatic run(int ncyc, int wdiv, int woff, int wskip,
                     int rdiv, int roff, int rskip, bit clr_on_slip);
    int wslot = 0, rslot = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      wr_stb = 0; rd_stb = 0; wr_fs = 0; flag_clr = 0;
      if (c % rdiv == roff) begin
        if (!(rskip != 0 && rslot % rskip == rskip - 1)) begin
          int len, d;
          rd_stb = 1;
          len = e1_mode ? 256 : FB;
          q_bit.push_back(e1_mode ? map_e1(rfn, rpos) : gen(rfn, rpos));
          q_fs.push_back(rpos == 0);
          q_care.push_back(rfn != 0);
          if (rpos == len - 1) begin
            d = wfn + ((widx >= FB - GUARD) ? 1 : 0) - rfn;
            rpos = 0;
            if (d <= 1) begin
              exp_empty = 1;                // R4 repeat
              if (clr_on_slip) flag_clr = 1;
            end else if (d >= 3) begin
              rfn += 2;                     // R5 skip
              exp_full = 1;
              if (clr_on_slip) flag_clr = 1;
            end else rfn++;
          end else rpos++;
        end
        rslot++;
      end
      if (c % wdiv == woff) begin
        if (!(wskip != 0 && wslot % wskip == wskip - 1)) begin
          wr_stb = 1;
          wr_bit = gen(wfn, widx);
          wr_fs = (widx == 0);
          widx++;
          if (widx == FB) begin widx = 0; wfn++; end
        end
        wslot++;
      end
    end
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; wr_fs = 0; flag_clr = 0;
    @(negedge clk);
  endtask

  task automatic check_flags(string req);
    check({req, " slip_flag"}, slip_flag, exp_empty | exp_full);
    check({req, " empty_slip"}, empty_slip, exp_empty);
    check({req, " full_slip"}, full_slip, exp_full);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_bit", rd_bit, 0);
    check("R1 rd_fs", rd_fs, 0);
    check("R1 flags", {slip_flag, empty_slip, full_slip}, 0);
    rst_n = 1'b1;

    // R2 / R7: equal rates, writer a strobe ahead
    do_recenter();
    run(4 * FB * 5, 4, 0, 0, 4, 1, 0, 0);
    check("R7 no slip", slip_flag, 0);
    check_flags("R7");
    begin
      bit held;
      held = rd_bit;
      repeat (5) @(negedge clk);
      check("R9 hold", rd_bit, held);
    end

    // R4 / R6: slow writer, clear raised on the slip strobe itself
    do_recenter();
    run(4 * FB * 9, 4, 0, 16, 4, 1, 0, 1);
    check("R4 repeat seen", empty_slip, 1);
    check_flags("R6 set wins");
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    check("R6 cleared", {slip_flag, empty_slip, full_slip}, 0);

    // R5: fast writer
    do_recenter();
    run(19000, 4, 0, 0, 4, 1, 16, 0);
    check("R5 skip seen", full_slip, 1);
    check_flags("R5");

    // R3: timeslot format
    e1_mode = 1'b1;
    do_recenter();
    run(3 * 256 * 6, 4, 0, 0, 3, 2, 0, 0);
    check_flags("R3");
    e1_mode = 1'b0;

    // R8: bypass
    es_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_stb = 1; wr_bit = bit'(i % 2 == 0); wr_fs = bit'(i == 3);
      @(negedge clk);
      wr_stb = 0;
      check("R8 bit", rd_bit, (i % 2 == 0));
      check("R8 fs", rd_fs, (i == 3));
      rd_stb = 1;
      @(negedge clk);
      rd_stb = 0;
      check("R8 read ignored", rd_bit, (i % 2 == 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule